// File: doc/BRIEF.md
# Tiered Write-Protection Controller for Timer Configuration

This block guards a small set of timer configuration fields against accidental
rewrites by software. Every register write reaches it as an address, a data
word and a write strobe. The block holds a two-bit protection level. Software
may set that level once after reset. For each field that a write touches, the
block either commits the new value or drops it without any report. The choice
depends on the current protection level and, for some per-channel fields, on
whether that channel is currently set up as an output.

Protection is cumulative. Each higher level keeps everything the lower levels
guard and adds more fields. The per-channel polarity, compare-mode and preload
fields are guarded only while the stored channel direction selects output.
All fields are held inside the block and driven out as plain outputs, so the
timer logic nearby can use them directly.

The register map has four word addresses. Address 0 is the guard word:
dead-time in bits 7:0, protection level in bits 9:8, idle off-state select in
bit 10, run off-state select in bit 11, break enable in bit 12, break polarity
in bit 13 and automatic output enable in bit 14. Address 1 holds the idle
levels: bit 2c is the idle level of channel c and bit 2c+1 is the idle level of
its complementary output. Address 2 holds the polarities: bit 2c is the
polarity of channel c and bit 2c+1 is the complementary polarity. Address 3
holds one 8-bit slice per channel, starting at bit 8c. In that slice, bits 1:0
are the direction select, where 00 means output and any other value means
input. Bit 2 is the preload enable and bits 5:3 are the compare mode.

Top module: `lockprot_top`

## Requirements
- R1: While rstN is low, and after it rises, every stored field reads zero: the protection level, the lockSet flag, dead-time, the off-state selects, the break and output-enable bits, the idle levels, the polarities, the direction selects, the preload bits and the compare modes.
- R2: The first write to address 0 after reset sets lockSet and loads the protection level from bits 9:8, even when that value is 0. Any later write ignores bits 9:8 until the next reset.
- R3: At protection level 0, a write to any address commits all the fields it carries.
- R4: At level 1 or higher, writes do not change dead-time, break enable, break polarity, automatic output enable or the idle levels at address 1.
- R5: At level 2 or higher, writes do not change the idle or run off-state select bits.
- R6: At level 2 or higher, the polarity pair of a channel whose stored direction select is 00 cannot be written. The polarity pair of any other channel stays writable.
- R7: At level 3, the preload bit and compare mode of a channel whose stored direction select is 00 cannot be written. At levels below 3, or when the stored select is not 00, they stay writable.
- R8: The direction select fields can be written at every level. The output test for R6 and R7 uses the stored select from before the write, not the value being written.
- R9: When one write carries both guarded and open fields, the open fields update and the guarded fields keep their values.
- R10: While wrEn is low, no field changes, whatever is on wrAddr and wrData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Word address of the write |
| wrData | input | DATA_W (16) | Write data |
| lockLevel | output | 2 | Current protection level |
| lockSet | output | 1 | Set once the protection level has been written since reset |
| deadTime | output | 8 | Dead-time setting |
| offIdleSel | output | 1 | Idle-mode off-state select |
| offRunSel | output | 1 | Run-mode off-state select |
| brkEn | output | 1 | Break enable |
| brkPol | output | 1 | Break polarity |
| autoOutEn | output | 1 | Automatic output enable |
| idleLvl | output | NCH | Idle level per channel output |
| idleLvlN | output | NCH | Idle level per complementary output |
| chPol | output | NCH | Polarity per channel |
| chPolN | output | NCH | Complementary polarity per channel |
| chSel | output | 2*NCH | Direction select per channel, 00 means output |
| chPreload | output | NCH | Compare preload enable per channel |
| chMode | output | 3*NCH | Compare mode per channel |

## Verification
The main function is tested in two ways. Directed writes show that the
protection level is latched on the first guard write, including a write of
level 0. They also show that one guard write is split into committed and
dropped fields. Randomized rounds then fix a different protection level in each
round and mix writes to all four addresses. Some of these writes turn channels
between output and input in the same write that touches their mode or
polarity, which separates a design that tests the stored direction from one
that tests the incoming direction. Idle cycles with random data on the bus
while the strobe is low show that nothing commits without the strobe.

// File: rtl/lockprot_pkg.sv
package lockprot_pkg;

  typedef enum logic [1:0] {
    ADDR_GUARD = 2'd0,
    ADDR_IDLE  = 2'd1,
    ADDR_POL   = 2'd2,
    ADDR_MODE  = 2'd3
  } regAddr_t;

  // guard word layout
  localparam int DT_LSB    = 0;
  localparam int DT_W      = 8;
  localparam int LVL_LSB   = 8;
  localparam int LVL_W     = 2;
  localparam int OFFI_BIT  = 10;
  localparam int OFFR_BIT  = 11;
  localparam int BRKE_BIT  = 12;
  localparam int BRKP_BIT  = 13;
  localparam int AOE_BIT   = 14;
  localparam int GUARD_W   = 15;

  // per-channel mode slice layout
  localparam int SLICE_W   = 8;
  localparam int SEL_LSB   = 0;
  localparam int SEL_W     = 2;
  localparam int PRE_BIT   = 2;
  localparam int MODE_LSB  = 3;
  localparam int MODE_W    = 3;

  localparam logic [SEL_W-1:0] SEL_OUTPUT = '0;

  // strobes from control to datapath
  typedef struct packed {
    logic deadWr;
    logic breakWr;
    logic idleWr;
    logic offSelWr;
    logic polHit;
    logic modeHit;
  } wrStrobe_t;

endpackage

// File: rtl/lockprot_ctrl.sv
module lockprot_ctrl
  import lockprot_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NCH-1:0]       chIsOut,
  output wrStrobe_t            strb,
  output logic [NCH-1:0]       polOpen,
  output logic [NCH-1:0]       cfgOpen,
  output logic [LVL_W-1:0]     lockLevel,
  output logic                 lockSet
);

  logic hitGuard, hitIdle, hitPol, hitMode;
  logic lockLoad;
  logic lvlGe1, lvlGe2, lvlIs3;

  assign hitGuard = wrEn && (regAddr_t'(wrAddr) == ADDR_GUARD);
  assign hitIdle  = wrEn && (regAddr_t'(wrAddr) == ADDR_IDLE);
  assign hitPol   = wrEn && (regAddr_t'(wrAddr) == ADDR_POL);
  assign hitMode  = wrEn && (regAddr_t'(wrAddr) == ADDR_MODE);

  assign lockLoad = hitGuard && !lockSet;

  assign lvlGe1 = (lockLevel != 2'd0);
  assign lvlGe2 = lockLevel[1];
  assign lvlIs3 = (lockLevel == 2'd3);

  // single-shot level register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockLevel <= '0;
      lockSet   <= 1'b0;
    end else if (lockLoad) begin
      lockLevel <= wrData[LVL_LSB +: LVL_W];
      lockSet   <= 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.deadWr   = hitGuard && !lvlGe1;
    strb.breakWr  = hitGuard && !lvlGe1;
    strb.idleWr   = hitIdle  && !lvlGe1;
    strb.offSelWr = hitGuard && !lvlGe2;
    strb.polHit   = hitPol;
    strb.modeHit  = hitMode;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chGuard
    assign polOpen[c] = !(lvlGe2 && chIsOut[c]);
    assign cfgOpen[c] = !(lvlIs3 && chIsOut[c]);
  end

endmodule

// File: rtl/lockprot_regs.sv
module lockprot_regs
  import lockprot_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    wrData,
  input  wrStrobe_t            strb,
  input  logic [NCH-1:0]       polOpen,
  input  logic [NCH-1:0]       cfgOpen,
  output logic [NCH-1:0]       chIsOut,
  output logic [DT_W-1:0]      deadTime,
  output logic                 offIdleSel,
  output logic                 offRunSel,
  output logic                 brkEn,
  output logic                 brkPol,
  output logic                 autoOutEn,
  output logic [NCH-1:0]       idleLvl,
  output logic [NCH-1:0]       idleLvlN,
  output logic [NCH-1:0]       chPol,
  output logic [NCH-1:0]       chPolN,
  output logic [SEL_W*NCH-1:0] chSel,
  output logic [NCH-1:0]       chPreload,
  output logic [MODE_W*NCH-1:0] chMode
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadTime <= '0;
    end else if (strb.deadWr) begin
      deadTime <= wrData[DT_LSB +: DT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkEn     <= 1'b0;
      brkPol    <= 1'b0;
      autoOutEn <= 1'b0;
    end else if (strb.breakWr) begin
      brkEn     <= wrData[BRKE_BIT];
      brkPol    <= wrData[BRKP_BIT];
      autoOutEn <= wrData[AOE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offIdleSel <= 1'b0;
      offRunSel  <= 1'b0;
    end else if (strb.offSelWr) begin
      offIdleSel <= wrData[OFFI_BIT];
      offRunSel  <= wrData[OFFR_BIT];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SLICE_W-1:0] slice;
    assign slice = wrData[c*SLICE_W +: SLICE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idleLvl[c]  <= 1'b0;
        idleLvlN[c] <= 1'b0;
      end else if (strb.idleWr) begin
        idleLvl[c]  <= wrData[2*c];
        idleLvlN[c] <= wrData[2*c+1];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chPol[c]  <= 1'b0;
        chPolN[c] <= 1'b0;
      end else if (strb.polHit && polOpen[c]) begin
        chPol[c]  <= wrData[2*c];
        chPolN[c] <= wrData[2*c+1];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chSel[c*SEL_W +: SEL_W] <= '0;
      end else if (strb.modeHit) begin
        chSel[c*SEL_W +: SEL_W] <= slice[SEL_LSB +: SEL_W];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chPreload[c]               <= 1'b0;
        chMode[c*MODE_W +: MODE_W] <= '0;
      end else if (strb.modeHit && cfgOpen[c]) begin
        chPreload[c]               <= slice[PRE_BIT];
        chMode[c*MODE_W +: MODE_W] <= slice[MODE_LSB +: MODE_W];
      end
    end

    assign chIsOut[c] = (chSel[c*SEL_W +: SEL_W] == SEL_OUTPUT);
  end

endmodule

// File: rtl/lockprot_top.sv
module lockprot_top
  import lockprot_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [1:0]            lockLevel,
  output logic                  lockSet,
  output logic [7:0]            deadTime,
  output logic                  offIdleSel,
  output logic                  offRunSel,
  output logic                  brkEn,
  output logic                  brkPol,
  output logic                  autoOutEn,
  output logic [NCH-1:0]        idleLvl,
  output logic [NCH-1:0]        idleLvlN,
  output logic [NCH-1:0]        chPol,
  output logic [NCH-1:0]        chPolN,
  output logic [2*NCH-1:0]      chSel,
  output logic [NCH-1:0]        chPreload,
  output logic [3*NCH-1:0]      chMode
);

  localparam int MIN_W = (NCH * SLICE_W > GUARD_W) ? NCH * SLICE_W : GUARD_W;

  initial begin
    if (DATA_W < MIN_W) $error("DATA_W too narrow for NCH");
  end

  wrStrobe_t      strb;
  logic [NCH-1:0] polOpen;
  logic [NCH-1:0] cfgOpen;
  logic [NCH-1:0] chIsOut;

  lockprot_ctrl #(.NCH(NCH), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .chIsOut   (chIsOut),
    .strb      (strb),
    .polOpen   (polOpen),
    .cfgOpen   (cfgOpen),
    .lockLevel (lockLevel),
    .lockSet   (lockSet)
  );

  lockprot_regs #(.NCH(NCH), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .strb       (strb),
    .polOpen    (polOpen),
    .cfgOpen    (cfgOpen),
    .chIsOut    (chIsOut),
    .deadTime   (deadTime),
    .offIdleSel (offIdleSel),
    .offRunSel  (offRunSel),
    .brkEn      (brkEn),
    .brkPol     (brkPol),
    .autoOutEn  (autoOutEn),
    .idleLvl    (idleLvl),
    .idleLvlN   (idleLvlN),
    .chPol      (chPol),
    .chPolN     (chPolN),
    .chSel      (chSel),
    .chPreload  (chPreload),
    .chMode     (chMode)
  );

endmodule

// File: rtl/lockprot_chk.sv
module lockprot_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       lockLevel,
  input logic             lockSet,
  input logic [7:0]       deadTime,
  input logic             offIdleSel,
  input logic             offRunSel,
  input logic             brkEn,
  input logic             brkPol,
  input logic             autoOutEn,
  input logic [NCH-1:0]   idleLvl,
  input logic [NCH-1:0]   idleLvlN,
  input logic [NCH-1:0]   chPol,
  input logic [NCH-1:0]   chPolN,
  input logic [2*NCH-1:0] chSel,
  input logic [NCH-1:0]   chPreload,
  input logic [3*NCH-1:0] chMode
);

  assert_lock_once_R2: assert property (@(posedge clk) disable iff (!rstN)
    lockSet |=> ($stable(lockLevel) && lockSet));

  assert_lvl1_freeze_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockLevel != 2'd0) |=> ($stable(deadTime) && $stable(brkEn) && $stable(brkPol)
                             && $stable(autoOutEn) && $stable(idleLvl) && $stable(idleLvlN)));

  assert_lvl2_offsel_R5: assert property (@(posedge clk) disable iff (!rstN)
    lockLevel[1] |=> ($stable(offIdleSel) && $stable(offRunSel)));

  assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(lockLevel) && $stable(deadTime) && $stable(chSel)
               && $stable(chMode) && $stable(chPol) && $stable(offRunSel)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_pol_guard_R6: assert property (@(posedge clk) disable iff (!rstN)
      (lockLevel[1] && chSel[2*c +: 2] == 2'b00) |=> ($stable(chPol[c]) && $stable(chPolN[c])));

    assert_mode_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
      (lockLevel == 2'd3 && chSel[2*c +: 2] == 2'b00)
        |=> ($stable(chPreload[c]) && $stable(chMode[3*c +: 3])));
  end

endmodule

bind lockprot_top lockprot_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .lockLevel  (lockLevel),
  .lockSet    (lockSet),
  .deadTime   (deadTime),
  .offIdleSel (offIdleSel),
  .offRunSel  (offRunSel),
  .brkEn      (brkEn),
  .brkPol     (brkPol),
  .autoOutEn  (autoOutEn),
  .idleLvl    (idleLvl),
  .idleLvlN   (idleLvlN),
  .chPol      (chPol),
  .chPolN     (chPolN),
  .chSel      (chSel),
  .chPreload  (chPreload),
  .chMode     (chMode)
);

// File: tb/tb_lockprot_top.sv
module tb_lockprot_top;

  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;

  logic [1:0] lockLevel;
  logic lockSet;
  logic [7:0] deadTime;
  logic offIdleSel, offRunSel, brkEn, brkPol, autoOutEn;
  logic [NCH-1:0] idleLvl, idleLvlN, chPol, chPolN, chPreload;
  logic [2*NCH-1:0] chSel;
  logic [3*NCH-1:0] chMode;

  int checks = 0;
  int errors = 0;
  bit compareOn = 1'b0;

  always #4 clk = ~clk;

  lockprot_top #(.NCH(NCH), .DATA_W(16)) dut (.*);

  // behavioural reference
  int mLock, mSet, mDead, mOffI, mOffR, mBrkE, mBrkP, mAoe;
  int mIdle[NCH], mIdleN[NCH], mPol[NCH], mPolN[NCH], mSel[NCH], mPre[NCH], mMode[NCH];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLock = 0; mSet = 0; mDead = 0; mOffI = 0; mOffR = 0;
      mBrkE = 0; mBrkP = 0; mAoe = 0;
      for (int c = 0; c < NCH; c++) begin
        mIdle[c] = 0; mIdleN[c] = 0; mPol[c] = 0; mPolN[c] = 0;
        mSel[c] = 0; mPre[c] = 0; mMode[c] = 0;
      end
    end else if (wrEn) begin
      int lv;
      lv = mLock;
      case (wrAddr)
        2'd0: begin
          if (mSet == 0) begin mSet = 1; mLock = int'(wrData[9:8]); end
          if (lv == 0) begin
            mDead = int'(wrData[7:0]);
            mBrkE = int'(wrData[12]); mBrkP = int'(wrData[13]); mAoe = int'(wrData[14]);
          end
          if (lv < 2) begin mOffI = int'(wrData[10]); mOffR = int'(wrData[11]); end
        end
        2'd1: if (lv == 0)
          for (int c = 0; c < NCH; c++) begin
            mIdle[c] = int'(wrData[2*c]); mIdleN[c] = int'(wrData[2*c+1]);
          end
        2'd2:
          for (int c = 0; c < NCH; c++)
            if (!(lv >= 2 && mSel[c] == 0)) begin
              mPol[c] = int'(wrData[2*c]); mPolN[c] = int'(wrData[2*c+1]);
            end
        default:
          for (int c = 0; c < NCH; c++) begin
            if (!(lv == 3 && mSel[c] == 0)) begin
              mPre[c]  = int'(wrData[8*c+2]);
              mMode[c] = int'((wrData >> (8*c+3)) & 16'h7);
            end
            mSel[c] = int'((wrData >> (8*c)) & 16'h3);
          end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compareOn) begin
      chk("R2 lockLevel", int'(lockLevel), mLock);
      chk("R2 lockSet", int'(lockSet), mSet);
      chk("R4 deadTime", int'(deadTime), mDead);
      chk("R4 brkEn", int'(brkEn), mBrkE);
      chk("R4 brkPol", int'(brkPol), mBrkP);
      chk("R4 autoOutEn", int'(autoOutEn), mAoe);
      chk("R5 offIdleSel", int'(offIdleSel), mOffI);
      chk("R5 offRunSel", int'(offRunSel), mOffR);
      for (int c = 0; c < NCH; c++) begin
        chk("R4 idleLvl", int'(idleLvl[c]), mIdle[c]);
        chk("R4 idleLvlN", int'(idleLvlN[c]), mIdleN[c]);
        chk("R6 chPol", int'(chPol[c]), mPol[c]);
        chk("R6 chPolN", int'(chPolN[c]), mPolN[c]);
        chk("R8 chSel", int'(chSel[2*c +: 2]), mSel[c]);
        chk("R7 chPreload", int'(chPreload[c]), mPre[c]);
        chk("R7 chMode", int'(chMode[3*c +: 3]), mMode[c]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareOn = 1'b1;
    rstN = 1'b1;

    // R1: reset state
    doReset();
    @(negedge clk);
    chk("R1 lockLevel", int'(lockLevel), 0);
    chk("R1 lockSet", int'(lockSet), 0);
    chk("R1 deadTime", int'(deadTime), 0);
    chk("R1 chMode", int'(chMode), 0);

    // R3 / R2: level-0 lock write still lets later fields through
    wr(2'd0, 16'h00A5);
    chk("R3 deadTime", int'(deadTime), 8'hA5);
    chk("R2 lockSet after level-0 write", int'(lockSet), 1);
    wr(2'd0, 16'h035A);
    chk("R3 deadTime rewrite", int'(deadTime), 8'h5A);
    chk("R2 lockLevel stays 0", int'(lockLevel), 0);
    wr(2'd3, 16'h2D2C);
    chk("R3 chMode", int'(chMode), 6'b101101);

    // R9: mixed write at level 1
    doReset();
    wr(2'd0, 16'h0111);
    wr(2'd0, 16'h0C22);
    chk("R9 deadTime kept", int'(deadTime), 8'h11);
    chk("R9 offIdleSel updated", int'(offIdleSel), 1);
    chk("R9 offRunSel updated", int'(offRunSel), 1);

    // R10: strobe low
    @(negedge clk);
    wrAddr = 2'd3; wrData = 16'hFFFF; wrEn = 1'b0;
    @(negedge clk);
    chk("R10 chMode unchanged", int'(chMode), 0);
    chk("R10 chSel unchanged", int'(chSel), 0);

    // R8: select change in the same write as a guarded mode write, level 3
    doReset();
    wr(2'd0, 16'h0300);
    wr(2'd3, 16'h3D3D);
    chk("R8 chSel written at level 3", int'(chSel), 4'b0101);
    chk("R7 chMode guarded by stored select", int'(chMode), 0);
    wr(2'd3, 16'h2C2C);
    chk("R7 chMode open for input channel", int'(chMode), 6'b101101);

    // randomized rounds, one per level and more
    for (int r = 0; r < 12; r++) begin
      doReset();
      repeat (6) wr(2'($urandom_range(1, 3)), 16'($urandom));
      wr(2'd0, 16'(($urandom & 16'hFCFF) | ((r % 4) << 8)));
      for (int k = 0; k < 60; k++) begin
        if ($urandom_range(0, 4) == 0) begin
          @(negedge clk);
          wrAddr = 2'($urandom); wrData = 16'($urandom);
        end else begin
          wr(2'($urandom), 16'($urandom & 16'hFCFC | ($urandom_range(0, 3) == 0 ? 16'h0 : 16'h0101)));
        end
      end
    end

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule